// File: doc/BRIEF.md
# Cable Unplug Detector and Power Mode Controller

This block watches a one-cycle link-activity pulse from the line receiver and decides whether a cable is attached. When it sees no activity for a long, parameterized number of clock cycles, it clears the plugged status bit that the MAC reads. If automatic power reduction is allowed, it also moves the port into a reduced-power state. In that state only the activity-detection path stays alive, and the interface clock is forced to its slow rate.

Leaving the unplugged condition is deliberately harder than entering it. A single stray pulse is not enough. A set number of activity pulses must arrive inside a short window that opens with the first of them. Only then does the block report the cable as plugged again and leave reduced power.

Two software-owned disable bits come in as plain inputs. Either one keeps the port at full power while unplugged. Clearing both of them while the port is unplugged sends it into reduced power.

Top module: `link_sleep_ctrl`

## Requirements
- R1: During and after reset, before any timeout, `link_up` is 1, `low_power` is 0 and `clk_fast` equals `speed_100`.
- R2: While plugged, `link_up` falls in the cycle after the SILENCE_CYCLES-th consecutive cycle with `act_pulse` low.
- R3: Any `act_pulse` while plugged restarts the silence count. Quiet stretches of SILENCE_CYCLES-1 cycles separated by pulses never clear `link_up`.
- R4: When the timeout fires with both `dyn_pd_dis` and `rpd_dis` at 0, `low_power` rises in the same cycle that `link_up` falls.
- R5: When the timeout fires with either disable bit at 1, `link_up` falls and `low_power` stays 0.
- R6: While unplugged, clearing both disable bits sets `low_power` in the next cycle. Setting either bit while in reduced power clears `low_power` in the next cycle, and `link_up` stays 0.
- R7: `clk_fast` is 1 (fast interface clock) exactly when `speed_100` is 1 and `low_power` is 0. It is 0 (slow rate, never stopped) otherwise.
- R8: While unplugged, a window opens on an activity pulse and covers that cycle and the next WAKE_WINDOW-1 cycles. If WAKE_PULSES pulses fall inside the window, `link_up` rises and `low_power` falls in the cycle after the last of them.
- R9: A pulse that arrives after the window has expired does not wake the port. It opens a new window as that window's first pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| act_pulse | input | 1 | One-cycle link-activity indication |
| speed_100 | input | 1 | 1 = 100 Mb/s mode, 0 = 10 Mb/s mode |
| dyn_pd_dis | input | 1 | Register bit: disable dynamic power-down |
| rpd_dis | input | 1 | Register bit: disable reduced power-down |
| link_up | output | 1 | Plugged status bit seen by the MAC (1 = plugged) |
| low_power | output | 1 | Reduced-power state flag |
| clk_fast | output | 1 | Interface clock select (1 = fast rate, 0 = slow rate) |

## Verification
The timer is driven with pulse trains whose gaps sit exactly one cycle below and exactly at the timeout. This separates an off-by-one in the silence count from a correct restart. Wake-up is tried with three kinds of pulse bursts: pulses packed well inside the window, a final pulse on the last cycle of the window, and a final pulse one cycle past it. These tell a correct window bound from one that is too long or too short, and show that the late pulse opens a new window. The disable bits are toggled at timeout and while unplugged, and the speed input is swung in every state, to separate a full-power unplugged port from a sleeping one.

// File: rtl/lsc_pkg.sv
package lsc_pkg;

    typedef enum logic [1:0] {
        PM_LINKED  = 2'd0,
        PM_NOCABLE = 2'd1,
        PM_SLEEP   = 2'd2
    } pm_state_e;

    typedef struct packed {
        logic link_up;
        logic low_power;
        logic clk_fast;
    } pm_out_t;

    function automatic logic pd_allowed(input logic dyn_dis, input logic red_dis);
        return !dyn_dis && !red_dis;
    endfunction

    function automatic pm_out_t decode_outputs(input pm_state_e st, input logic spd);
        pm_out_t o;
        o.link_up   = (st == PM_LINKED);
        o.low_power = (st == PM_SLEEP);
        o.clk_fast  = spd && (st != PM_SLEEP);
        return o;
    endfunction

endpackage

// File: rtl/lsc_silence_timer.sv
module lsc_silence_timer #(
    parameter int SILENCE_CYCLES = 1000
) (
    input  logic clk,
    input  logic rst,
    input  logic en,
    input  logic act,
    output logic done_o
);
    localparam int CW = $clog2(SILENCE_CYCLES + 1);
    localparam logic [CW-1:0] LAST = CW'(SILENCE_CYCLES - 1);

    logic [CW-1:0] cnt;

    assign done_o = en && !act && (cnt == LAST);

    always_ff @(posedge clk) begin
        if (rst || !en || act || done_o)
            cnt <= '0;
        else
            cnt <= cnt + 1'b1;
    end

    // R3
    act_restart_chk: assert property (@(posedge clk) disable iff (rst)
        act |=> (cnt == '0));

endmodule

// File: rtl/lsc_wake_qual.sv
module lsc_wake_qual #(
    parameter int WAKE_WINDOW = 200,
    parameter int WAKE_PULSES = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic en,
    input  logic act,
    output logic wake_o
);
    localparam int PW = $clog2(WAKE_PULSES + 1);
    localparam int WW = $clog2(WAKE_WINDOW + 1);
    localparam logic [PW-1:0] NEED_M1 = PW'(WAKE_PULSES - 1);
    localparam logic [WW-1:0] WLIM    = WW'(WAKE_WINDOW);

    logic [PW-1:0] pcnt;
    logic [WW-1:0] wcnt;
    logic          expired;

    assign expired = (pcnt != '0) && (wcnt >= WLIM);
    assign wake_o  = en && act && !expired && (pcnt == NEED_M1);

    always_ff @(posedge clk) begin
        if (rst || !en || wake_o) begin
            pcnt <= '0;
            wcnt <= '0;
        end else if (pcnt == '0 || expired) begin
            pcnt <= act ? PW'(1) : '0;
            wcnt <= act ? WW'(1) : '0;
        end else begin
            pcnt <= pcnt + PW'(act);
            wcnt <= wcnt + 1'b1;
        end
    end

    // R8
    pulse_bound_chk: assert property (@(posedge clk) disable iff (rst)
        en |-> (pcnt < PW'(WAKE_PULSES)));

    // R9
    window_restart_chk: assert property (@(posedge clk) disable iff (rst)
        (en && expired && act) |=> (pcnt == PW'(1)));

endmodule

// File: rtl/link_sleep_ctrl.sv
module link_sleep_ctrl
    import lsc_pkg::*;
#(
    parameter int SILENCE_CYCLES = 165_000_000,
    parameter int WAKE_WINDOW    = 12_500_000,
    parameter int WAKE_PULSES    = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic act_pulse,
    input  logic speed_100,
    input  logic dyn_pd_dis,
    input  logic rpd_dis,
    output logic link_up,
    output logic low_power,
    output logic clk_fast
);
    pm_state_e state, nxt;
    pm_out_t   outs;
    logic      pd_ok, silence_done, wake_fire;

    assign pd_ok = pd_allowed(dyn_pd_dis, rpd_dis);

    lsc_silence_timer #(.SILENCE_CYCLES(SILENCE_CYCLES)) u_timer (
        .clk    (clk),
        .rst    (rst),
        .en     (state == PM_LINKED),
        .act    (act_pulse),
        .done_o (silence_done)
    );

    lsc_wake_qual #(.WAKE_WINDOW(WAKE_WINDOW), .WAKE_PULSES(WAKE_PULSES)) u_wake (
        .clk    (clk),
        .rst    (rst),
        .en     (state != PM_LINKED),
        .act    (act_pulse),
        .wake_o (wake_fire)
    );

    always_comb begin
        nxt = state;
        unique case (state)
            PM_LINKED:  if (silence_done) nxt = pd_ok ? PM_SLEEP : PM_NOCABLE;
            PM_NOCABLE: if (wake_fire) nxt = PM_LINKED;
                        else if (pd_ok) nxt = PM_SLEEP;
            PM_SLEEP:   if (wake_fire) nxt = PM_LINKED;
                        else if (!pd_ok) nxt = PM_NOCABLE;
            default:    nxt = PM_LINKED;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state <= PM_LINKED;
        else     state <= nxt;
    end

    assign outs      = decode_outputs(state, speed_100);
    assign link_up   = outs.link_up;
    assign low_power = outs.low_power;
    assign clk_fast  = outs.clk_fast;

    // R2
    unplug_cause_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(link_up) |-> $past(silence_done));

    // R8
    plug_cause_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(link_up) |-> $past(wake_fire));

    // R4
    sleep_entry_chk: assert property (@(posedge clk) disable iff (rst)
        (link_up && silence_done && pd_ok) |=> (low_power && !link_up));

    // R7
    slow_clock_chk: assert property (@(posedge clk) disable iff (rst)
        low_power |-> !clk_fast);

endmodule

// File: tb/sim_link_sleep_ctrl.sv
module sim_link_sleep_ctrl;
    localparam int SIL = 200;
    localparam int WIN = 40;
    localparam int PUL = 3;

    logic clk = 0, rst = 1, act = 0, spd = 1, dpd = 0, rpd = 0;
    logic link_up, low_power, clk_fast;
    int   n_checks = 0, n_errors = 0;
    string cur_req = "R1";

    // behavioural reference state
    int m_state = 0;   // 0 plugged, 1 unplugged full power, 2 sleeping
    int quiet = 0, wp = 0, wage = 0;

    always #4 clk = ~clk;

    link_sleep_ctrl #(.SILENCE_CYCLES(SIL), .WAKE_WINDOW(WIN), .WAKE_PULSES(PUL)) u0 (
        .clk(clk), .rst(rst), .act_pulse(act), .speed_100(spd),
        .dyn_pd_dis(dpd), .rpd_dis(rpd),
        .link_up(link_up), .low_power(low_power), .clk_fast(clk_fast)
    );

    always @(posedge clk) begin
        bit ok, wake;
        ok = !dpd && !rpd;
        wake = 0;
        if (rst) begin
            m_state = 0; quiet = 0; wp = 0; wage = 0;
        end else if (m_state == 0) begin
            quiet = act ? 0 : quiet + 1;
            if (quiet == SIL) begin
                m_state = ok ? 2 : 1;
                quiet = 0;
            end
        end else begin
            if (wp > 0 && wage >= WIN) begin wp = 0; wage = 0; end
            if (wp == 0) begin
                if (act) begin wp = 1; wage = 1; end
            end else begin
                wage++;
                if (act) wp++;
                if (wp == PUL) wake = 1;
            end
            if (wake) begin m_state = 0; wp = 0; wage = 0; quiet = 0; end
            else if (m_state == 1 && ok) m_state = 2;
            else if (m_state == 2 && !ok) m_state = 1;
        end
    end

    task automatic check(input logic actual, input logic expected, input string what);
        n_checks++;
        if (actual !== expected) begin
            n_errors++;
            $display("FAIL %s %s: actual %b expected %b at %0t", cur_req, what, actual, expected, $time);
        end
    endtask

    always @(negedge clk) begin
        if (!rst) begin
            check(link_up,   (m_state == 0), "link_up");
            check(low_power, (m_state == 2), "low_power");
            check(clk_fast,  spd && (m_state != 2), "clk_fast R7");
        end
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
        #1;
    endtask

    task automatic pulse();
        act = 1; tick(1); act = 0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_errors++;
        $display("FAIL watchdog: actual hung expected done");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        tick(3);
        cur_req = "R1";
        check(link_up, 1'b1, "reset link_up");
        check(low_power, 1'b0, "reset low_power");
        check(clk_fast, 1'b1, "reset clk_fast");
        rst = 0;
        tick(2);
        spd = 0; tick(2); spd = 1; tick(1);

        // R3: gaps of SIL-1 quiet cycles never time out
        cur_req = "R3";
        for (int i = 0; i < 4; i++) begin pulse(); tick(SIL - 1); end
        check(link_up, 1'b1, "R3 link kept");

        // R2 + R4: exact timeout into sleep
        cur_req = "R2";
        pulse();
        tick(SIL - 1);
        check(link_up, 1'b1, "one cycle before timeout");
        tick(1);
        cur_req = "R4";
        check(link_up, 1'b0, "R2 after timeout");
        check(low_power, 1'b1, "R4 sleeping");
        check(clk_fast, 1'b0, "R7 slow in sleep");
        spd = 0; tick(3); spd = 1; tick(3);

        // R9: pulses spaced wider than the window
        cur_req = "R9";
        for (int i = 0; i < 4; i++) begin pulse(); tick(WIN); end
        check(link_up, 1'b0, "R9 no wake");

        // R9: third pulse one cycle past window, then window restarted by it
        pulse(); tick(19); pulse(); tick(19);
        pulse();          // index 40: expired, opens new window
        check(link_up, 1'b0, "R9 late pulse");
        tick(WIN + 5);

        // R8: third pulse on last window cycle (index 39)
        cur_req = "R8";
        pulse(); tick(19); pulse(); tick(18); pulse();
        check(link_up, 1'b1, "R8 woke at window edge");
        check(low_power, 1'b0, "R8 awake");
        tick(5);

        // R5: timeout with a disable bit set
        cur_req = "R5";
        dpd = 1;
        tick(SIL + 2);
        check(link_up, 1'b0, "R5 unplugged");
        check(low_power, 1'b0, "R5 full power");
        check(clk_fast, 1'b1, "R7 fast while unplugged awake");

        // R6: clearing the bits sends it to sleep, setting one wakes power
        cur_req = "R6";
        dpd = 0; tick(1);
        check(low_power, 1'b1, "R6 sleep after clear");
        rpd = 1; tick(1);
        check(low_power, 1'b0, "R6 leave sleep");
        check(link_up, 1'b0, "R6 still unplugged");
        rpd = 0; tick(2);

        // R8: packed burst wakes
        cur_req = "R8";
        pulse(); pulse(); pulse();
        check(link_up, 1'b1, "R8 packed burst");
        tick(4);

        // R5 with the other bit
        cur_req = "R5";
        rpd = 1; tick(SIL + 2);
        check(low_power, 1'b0, "R5 other bit");
        rpd = 0; tick(3);
        check(low_power, 1'b1, "R6 sleep again");

        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end
endmodule